// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block connects a simple synchronous processor bus to an asynchronous DRAM array. A request arrives as a one-cycle pulse that carries a full word address, a write flag and write data. The controller splits the address into a row half and a column half and presents them one after the other on a shared address bus. It sequences the active-low row strobe, column strobe and write enable, and it holds the processor in a wait state until the access has finished.

After an access the row stays open, with the row strobe held low. When the next request falls in the same row, the controller skips the row cycle. It raises the column strobe, drives the new column and lowers the column strobe again. A request to a different row first releases the row strobe for a precharge interval, then performs a full row-then-column cycle.

Every strobe phase is counted in whole clock cycles and set by a parameter. With the default parameters a row change takes 4 cycles and a same-row access takes 3.

Top module: `pgdram_ctrl`

## Requirements
- R1: While reset is applied and after its release with no request, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `dram_dq_oe`, `cpu_hold` and `cpu_ready` are low, and `cpu_rdata` is zero.
- R2: The row half of the address (bits ADDR_W-1 down to COL_W of `cpu_addr`) is on `dram_addr` when `dram_ras_n` falls. The column half (bits COL_W-1 down to 0) is on `dram_addr` when `dram_cas_n` falls. `dram_cas_n` falls only while `dram_ras_n` is low.
- R3: A request to a row other than the open one gives `cpu_ready` exactly T_PRE+T_RCD+T_CAS cycles after the request cycle (4 by default). During the access `dram_ras_n` is high for T_PRE cycles and then falls exactly once.
- R4: A request to the open row gives `cpu_ready` exactly T_CP+T_CAS cycles after the request cycle (3 by default). `dram_ras_n` stays low for the whole access.
- R5: The first request after reset is always handled as a row change, whatever its address.
- R6: Read data is sampled from `dram_dq_in` only at the end of T_CAS cycles of `dram_cas_n` low, and it is shown on `cpu_rdata` in the cycle in which `cpu_ready` is high.
- R7: For a write, `dram_we_n` is low and `dram_dq_oe` is high with the write data on `dram_dq_out` for at least one cycle before `dram_cas_n` falls. Both stay so until `dram_cas_n` rises.
- R8: `cpu_hold` is high from the cycle after the request until the access ends, and it falls together with the `cpu_ready` pulse. A request made while `cpu_hold` is high is ignored: it causes no memory access and no ready pulse.
- R9: `cpu_ready` is high for exactly one cycle per accepted request.
- R10: Between accesses the last row stays open: `dram_ras_n` is low and `dram_cas_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle request pulse |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ROW_W+COL_W | Word address, row half in the upper bits |
| cpu_wdata | input | DATA_W | Write data |
| cpu_hold | output | 1 | Wait indication, high while an access is in progress |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Write data toward the array |
| dram_dq_oe | output | 1 | Data output enable toward the array |
| dram_dq_in | input | DATA_W | Read data from the array |

## Verification
If a request is sampled at clock edge k, `cpu_ready` and the read data are due right after edge k+4 on a row change and right after edge k+3 on a same-row hit. `cpu_ready` must stay low after every earlier edge. The bench computes hit or miss from its own open-row record. It samples one time unit after each falling clock edge and checks that `cpu_ready` is low on every earlier cycle and high on exactly the due cycle. Its DRAM model records the address at each strobe fall. Until the column strobe has been low for T_CAS samples, the model drives the complement of the stored word, so a controller that samples early reads wrong data. A model that counts the strobe falls and the precharge cycles in each access checks the row, column and write-enable ordering.

// File: rtl/pgdram_pkg.sv
`timescale 1ns/1ps
package pgdram_pkg;

   // Sequencer phases. PRE: row strobe released (precharge).
   // RCD: row strobe low with row address. CP: column strobe high with
   // new column (page hit). STRB: column strobe low.
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_PRE  = 3'd1,
      PH_RCD  = 3'd2,
      PH_CP   = 3'd3,
      PH_STRB = 3'd4
   } phase_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pgdram_rowtrack.sv
`timescale 1ns/1ps
module pgdram_rowtrack #(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] row_in,
   input  logic             load,
   output logic             hit,
   output logic             open_vld,
   output logic [ROW_W-1:0] open_row
);

   logic             vld_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         row_q <= '0;
      end else if (load) begin
         vld_q <= 1'b1;
         row_q <= row_in;
      end
   end

   assign hit      = vld_q && (row_q == row_in);
   assign open_vld = vld_q;
   assign open_row = row_q;

   // R5: a load always installs the requested row, so the row compares equal next cycle
   a_r5_load_installs_row: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (open_vld && open_row == $past(row_in)));

endmodule

// File: rtl/pgdram_seq.sv
`timescale 1ns/1ps
module pgdram_seq
   import pgdram_pkg::*;
#(
   parameter int T_PRE = 1,
   parameter int T_RCD = 1,
   parameter int T_CP  = 1,
   parameter int T_CAS = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   start_hit,
   output phase_e phase,
   output logic   last_strobe,
   output logic   done
);

   localparam int MAXD = max_of(max_of(T_PRE, T_RCD), max_of(T_CP, T_CAS));
   localparam int CW   = $clog2(MAXD + 1);
   localparam logic [CW-1:0] L_PRE = CW'(T_PRE - 1);
   localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
   localparam logic [CW-1:0] L_CP  = CW'(T_CP - 1);
   localparam logic [CW-1:0] L_CAS = CW'(T_CAS - 1);

   generate
      if (T_PRE < 1 || T_RCD < 1 || T_CP < 1 || T_CAS < 1) begin : g_bad_timing
         $error("every strobe phase must last at least one cycle");
      end
   endgenerate

   phase_e        ph_q, ph_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          done_q;

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      unique case (ph_q)
         PH_IDLE: begin
            if (start) begin
               ph_d  = start_hit ? PH_CP : PH_PRE;
               cnt_d = start_hit ? L_CP : L_PRE;
            end
         end
         PH_PRE: begin
            if (cnt_q == '0) begin
               ph_d  = PH_RCD;
               cnt_d = L_RCD;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_RCD, PH_CP: begin
            if (cnt_q == '0) begin
               ph_d  = PH_STRB;
               cnt_d = L_CAS;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_STRB: begin
            if (cnt_q == '0) begin
               ph_d  = PH_IDLE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: begin
            ph_d  = PH_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         done_q <= last_strobe;
      end
   end

   assign phase       = ph_q;
   assign last_strobe = (ph_q == PH_STRB) && (cnt_q == '0);
   assign done        = done_q;

   // R9: completion is a single-cycle pulse
   a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: precharge is followed only by more precharge or the row phase
   a_r3_precharge_then_row: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_PRE) |=> (ph_q == PH_PRE || ph_q == PH_RCD));

endmodule

// File: rtl/pgdram_pins.sv
`timescale 1ns/1ps
module pgdram_pins
   import pgdram_pkg::*;
#(
   parameter int ROW_W  = 10,
   parameter int COL_W  = 10,
   parameter int DATA_W = 16,
   parameter int AW     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  logic              row_open,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [AW-1:0]     dram_addr,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rdata
);

   logic [AW-1:0] row_x, col_x;

   generate
      if (ROW_W < AW) begin : g_row_pad
         assign row_x = {{(AW-ROW_W){1'b0}}, row};
      end else begin : g_row_full
         assign row_x = row;
      end
      if (COL_W < AW) begin : g_col_pad
         assign col_x = {{(AW-COL_W){1'b0}}, col};
      end else begin : g_col_full
         assign col_x = col;
      end
   endgenerate

   logic drive_wr;

   always_comb begin
      unique case (phase)
         PH_PRE, PH_RCD: dram_addr = row_x;
         default:        dram_addr = col_x;
      endcase
   end

   always_comb begin
      unique case (phase)
         PH_IDLE: ras_n = !row_open;
         PH_PRE:  ras_n = 1'b1;
         default: ras_n = 1'b0;
      endcase
   end

   assign cas_n    = (phase != PH_STRB);
   assign drive_wr = wr && (phase == PH_RCD || phase == PH_CP || phase == PH_STRB);
   assign we_n     = !drive_wr;
   assign dq_oe    = drive_wr;
   assign dq_out   = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (capture && !wr)
         rdata <= dq_in;
   end

   // R2: the column strobe only falls inside an open row
   a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> !ras_n);

   // R7: write enable set up a cycle before the column strobe falls
   a_r7_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !we_n) |-> $past(!we_n && dq_oe));

   // R7: write enable held while the column strobe is low
   a_r7_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && !we_n) |=> (cas_n || !we_n));

endmodule

// File: rtl/pgdram_ctrl.sv
`timescale 1ns/1ps
module pgdram_ctrl
   import pgdram_pkg::*;
#(
   parameter int ROW_W  = 10,
   parameter int COL_W  = 10,
   parameter int DATA_W = 16,
   parameter int T_PRE  = 1,
   parameter int T_RCD  = 1,
   parameter int T_CP   = 1,
   parameter int T_CAS  = 2,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_hold,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [AW-1:0]     dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);

   localparam int MISS_CYC = T_PRE + T_RCD + T_CAS;
   localparam int HIT_CYC  = T_CP + T_CAS;
   localparam int LW       = $clog2(MISS_CYC + HIT_CYC + 2);

   generate
      if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("row, column and data widths must be positive");
      end
   endgenerate

   phase_e             phase;
   logic               accept, row_hit, row_vld, last_strobe, done;
   logic [ROW_W-1:0]   open_row;
   logic [COL_W-1:0]   col_q;
   logic               we_q;
   logic [DATA_W-1:0]  wd_q;

   assign accept = cpu_req && (phase == PH_IDLE);

   pgdram_rowtrack #(.ROW_W(ROW_W)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_in   (cpu_addr[ADDR_W-1:COL_W]),
      .load     (accept && !row_hit),
      .hit      (row_hit),
      .open_vld (row_vld),
      .open_row (open_row)
   );

   pgdram_seq #(
      .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CP(T_CP), .T_CAS(T_CAS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_hit   (row_hit),
      .phase       (phase),
      .last_strobe (last_strobe),
      .done        (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         we_q  <= 1'b0;
         wd_q  <= '0;
      end else if (accept) begin
         col_q <= cpu_addr[COL_W-1:0];
         we_q  <= cpu_we;
         wd_q  <= cpu_wdata;
      end
   end

   pgdram_pins #(
      .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .AW(AW)
   ) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .row_open  (row_vld),
      .row       (open_row),
      .col       (col_q),
      .wr        (we_q),
      .wdata     (wd_q),
      .capture   (last_strobe),
      .dq_in     (dram_dq_in),
      .dram_addr (dram_addr),
      .ras_n     (dram_ras_n),
      .cas_n     (dram_cas_n),
      .we_n      (dram_we_n),
      .dq_out    (dram_dq_out),
      .dq_oe     (dram_dq_oe),
      .rdata     (cpu_rdata)
   );

   assign cpu_hold  = (phase != PH_IDLE);
   assign cpu_ready = done;

   // Latency tracking used by the checks below
   logic [LW-1:0] lat_q;
   logic          lat_hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q     <= '0;
         lat_hit_q <= 1'b0;
      end else if (accept) begin
         lat_q     <= '0;
         lat_hit_q <= row_hit;
      end else if (cpu_hold) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   a_r3_miss_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !lat_hit_q) |-> (lat_q == LW'(MISS_CYC)));

   a_r4_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && lat_hit_q) |-> (lat_q == LW'(HIT_CYC)));

   a_r4_ras_held_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hold && lat_hit_q) |-> !dram_ras_n);

   a_r8_hold_ends_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_hold) |-> cpu_ready);

   a_r10_row_left_open: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_hold && row_vld) |-> (!dram_ras_n && dram_cas_n));

endmodule

// File: tb/pgdram_ctrl_test.sv
`timescale 1ns/1ps
module pgdram_ctrl_test;

   localparam int RW = 4, CLW = 4, DW = 8;
   localparam int TP = 1, TR = 1, TC = 1, TS = 2;
   localparam int MISS_L = TP + TR + TS;
   localparam int HIT_L  = TC + TS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]    cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_hold, cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic [3:0]    dram_addr;
   logic          dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
   logic [DW-1:0] dram_dq_out;
   logic [DW-1:0] dq_model = '0;

   always #4 clk = ~clk;

   pgdram_ctrl #(
      .ROW_W(RW), .COL_W(CLW), .DATA_W(DW),
      .T_PRE(TP), .T_RCD(TR), .T_CP(TC), .T_CAS(TS)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_hold(cpu_hold),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .dram_addr(dram_addr),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_model)
   );

   int nchk = 0, nerr = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // DRAM model and strobe monitor, updated at each falling edge
   logic [DW-1:0] mem [256];
   logic [DW-1:0] shadow [256];
   logic [3:0] lat_row = '0, lat_col = '0;
   int ras_falls, cas_falls, pre_hi, we_bad, rdy_cnt, caslo;
   logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_oe = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_ras = 1'b1; p_cas = 1'b1; p_we = 1'b1; p_oe = 1'b0;
         dq_model = '0;
      end else begin
         if (p_ras && !dram_ras_n) begin
            ras_falls++;
            lat_row = dram_addr;
         end
         if (dram_ras_n && cpu_hold) pre_hi++;
         if (p_cas && !dram_cas_n) begin
            cas_falls++;
            lat_col = dram_addr;
            caslo = 0;
            if (!dram_we_n) begin
               if (p_we || !p_oe) we_bad++;
               mem[{lat_row, lat_col}] = dram_dq_out;
            end
         end
         if (!p_cas && !dram_cas_n && !p_we && dram_we_n) we_bad++;
         if (!dram_cas_n) begin
            caslo++;
            dq_model = (caslo >= TS) ? mem[{lat_row, lat_col}] : ~mem[{lat_row, lat_col}];
         end else begin
            dq_model = '0;
         end
         if (cpu_ready) rdy_cnt++;
         p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_oe = dram_dq_oe;
      end
   end

   logic [3:0] open_row = '0;
   bit         open_v = 0;

   task automatic access(input bit we, input logic [7:0] a, input logic [7:0] wd,
                         input bit intrude);
      bit exp_hit = open_v && (open_row == a[7:4]);
      int lat = exp_hit ? HIT_L : MISS_L;
      bit early = 0;
      ras_falls = 0; cas_falls = 0; pre_hi = 0; we_bad = 0; rdy_cnt = 0;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      @(negedge clk); #1;
      cpu_req = 1'b0;
      chk(cpu_hold == 1'b1, "R8", "hold after request", cpu_hold, 1);
      for (int j = 1; j < lat; j++) begin
         if (intrude && j == 1) begin
            cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h9F; cpu_wdata = 8'h5A;
         end else begin
            cpu_req = 1'b0;
         end
         @(negedge clk); #1;
         if (cpu_ready || !cpu_hold) early = 1;
      end
      cpu_req = 1'b0;
      @(negedge clk); #1;
      chk(!early, exp_hit ? "R4" : "R3", "ready or hold dropped early", early, 0);
      chk(cpu_ready == 1'b1, exp_hit ? "R4" : "R3", "ready at due cycle", cpu_ready, 1);
      chk(cpu_hold == 1'b0, "R8", "hold released with ready", cpu_hold, 0);
      if (!we)
         chk(cpu_rdata == shadow[a], "R6", "read data", cpu_rdata, shadow[a]);
      else
         shadow[a] = wd;
      chk(ras_falls == (exp_hit ? 0 : 1), exp_hit ? "R4" : "R3", "row strobe falls",
          ras_falls, exp_hit ? 0 : 1);
      if (!exp_hit) begin
         chk(pre_hi == TP, "R3", "precharge cycles", pre_hi, TP);
         chk(lat_row == a[7:4], "R2", "row address", lat_row, a[7:4]);
      end
      chk(cas_falls == 1 && lat_col == a[3:0], "R2", "column address", lat_col, a[3:0]);
      if (we) chk(we_bad == 0, "R7", "write enable ordering", we_bad, 0);
      open_row = a[7:4];
      open_v = 1;
      @(negedge clk); #1;
      chk(!dram_ras_n && dram_cas_n, "R10", "row left open",
          {dram_ras_n, dram_cas_n}, 2'b01);
      if (intrude) begin
         repeat (6) @(negedge clk);
         #1;
         chk(rdy_cnt == 1, "R9", "ready pulses", rdy_cnt, 1);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i) ^ 8'h3C;
         shadow[i] = 8'(i) ^ 8'h3C;
      end
      repeat (3) @(negedge clk);
      #1;
      chk(dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe, "R1", "strobes in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}, 4'b1110);
      chk(!cpu_hold && !cpu_ready && cpu_rdata == 0, "R1", "bus side in reset",
          {cpu_hold, cpu_ready}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(dram_ras_n && dram_cas_n && !cpu_hold && !cpu_ready, "R1", "idle after reset",
          {dram_ras_n, dram_cas_n, cpu_hold, cpu_ready}, 4'b1100);

      // R5: first access after reset is a miss (bench open_v is clear)
      for (int a = 0; a < 256; a++)
         access(1'b1, 8'(a), 8'((a * 5 + 1) & 8'hFF), 1'b0);
      for (int c = 0; c < 16; c++)
         for (int r = 0; r < 16; r++)
            access(1'b0, 8'({r[3:0], c[3:0]}), 8'h00, 1'b0);
      for (int a = 255; a >= 0; a--)
         access(1'b0, 8'(a), 8'h00, 1'b0);

      // R8: request during an access is ignored
      access(1'b1, 8'h12, 8'hA5, 1'b1);
      access(1'b0, 8'h9F, 8'h00, 1'b0);
      access(1'b0, 8'h12, 8'h00, 1'b0);

      // R5: after a second reset the same row is a miss again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; open_v = 0;
      @(negedge clk); #1;
      access(1'b0, 8'h13, 8'h00, 1'b0);
      access(1'b0, 8'h14, 8'h00, 1'b0);

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule